// File: doc/BRIEF.md
# Iterative DES Block Cipher Core

This block encrypts or decrypts one 64-bit block under a 64-bit key word. Only 56 bits of the key word are used: the low bit of each byte is a parity position and is dropped. The core computes one Feistel round per clock. Its key schedule runs beside the rounds, so one block takes 16 cycles.

An operation starts on a rising edge of `start_i`. The first round is computed in that same edge, straight from `data_i`, `key_i` and `encrypt_i`. The block's own registers then carry the remaining fifteen rounds. The result register is written when round 16 ends, and `done_o` pulses in the cycle that follows. Because a new start is accepted while that pulse is high, blocks can be fed back to back at one block every 16 cycles, which is 4 bits per clock. Each start may carry a new key and a new direction at no cost.

Chaining modes, triple encryption sequencing and bus wrappers belong to the logic around this core.

Top module: `des_iter_core`

## Requirements
- R1: With `encrypt_i` = 1, `result_o` equals the standard DES encryption of `data_i` under `key_i`. Bit 63 is the first bit of each word.
- R2: With `encrypt_i` = 0, `result_o` equals the DES decryption of `data_i` under `key_i`, so decrypting a ciphertext returns its plaintext.
- R3: Key bits 56, 48, 40, 32, 24, 16, 8 and 0 (the least significant bit of every byte) have no effect on the result.
- R4: Only a 0-to-1 transition of `start_i` begins an operation. Holding `start_i` high starts exactly one operation.
- R5: A rising edge on `start_i` while an operation is in progress is ignored. The running operation keeps its timing and its result.
- R6: `done_o` goes high exactly 16 clock cycles after the edge that accepted the start.
- R7: `done_o` is high for exactly one cycle per operation.
- R8: `result_o` changes only in the cycle in which `done_o` rises, and holds its value otherwise.
- R9: A start raised in the cycle in which `done_o` is high is accepted at once. Blocks therefore complete every 16 cycles with no dead cycle.
- R10: While `rst_ni` is low, and after it is released, `result_o` is zero and `done_o` is low. A reset during an operation aborts it with no completion.
- R11: `data_i`, `key_i` and `encrypt_i` are sampled only at the accepted start edge. Changes to them during an operation have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation request; its rising edge starts a block |
| encrypt_i | input | 1 | 1 = encrypt, 0 = decrypt; sampled at the start edge |
| data_i | input | 64 | Input block; bit 63 is the first bit |
| key_i | input | 64 | Key word; the low bit of each byte is ignored |
| result_o | output | 64 | Output block, held until the next completion |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
The completion pulse of one block and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising `start_i` in the very cycle in which it sees `done_o` high, with a different key, data word and direction. It then checks three things:
- the first ciphertext is still on `result_o` midway through the second operation;
- the second completion arrives exactly 16 cycles later;
- the second completion carries the correct known-answer result.

// File: rtl/des_pkg.sv
package des_pkg;

  localparam int BLOCK_W  = 64;
  localparam int HALF_W   = BLOCK_W / 2;
  localparam int KEY_W    = 64;
  localparam int CD_W     = 56;
  localparam int HCD_W    = CD_W / 2;
  localparam int SUBKEY_W = 48;
  localparam int ROUNDS   = 16;
  localparam int RND_W    = $clog2(ROUNDS);
  localparam int SBOX_N   = 8;
  localparam int SBOX_IN  = SUBKEY_W / SBOX_N;
  localparam int SBOX_OUT = HALF_W / SBOX_N;

  localparam int P_TAB [32] = '{
    16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
    2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25};

  localparam int PC1_TAB [56] = '{
    57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
    10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
    14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4};

  localparam int PC2_TAB [48] = '{
    14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
    23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  // 64 nibbles per box, entry {row,col} at nibble index row*16+col, entry 0 at MSB
  localparam logic [255:0] SBOX_TAB [8] = '{
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  // source bit (1-based, MSB first) of output bit i of the initial permutation
  function automatic int ip_src(input int i);
    int r, c;
    r = i / 8;
    c = i % 8;
    return (r < 4) ? (58 + 2 * r - 8 * c) : (57 + 2 * (r - 4) - 8 * c);
  endfunction

  function automatic logic [BLOCK_W-1:0] init_perm(input logic [BLOCK_W-1:0] x);
    logic [BLOCK_W-1:0] y;
    for (int i = 0; i < BLOCK_W; i++) y[BLOCK_W-1-i] = x[BLOCK_W-ip_src(i)];
    return y;
  endfunction

  function automatic logic [BLOCK_W-1:0] final_perm(input logic [BLOCK_W-1:0] x);
    logic [BLOCK_W-1:0] y;
    for (int i = 0; i < BLOCK_W; i++) y[BLOCK_W-ip_src(i)] = x[BLOCK_W-1-i];
    return y;
  endfunction

  function automatic logic [SUBKEY_W-1:0] expand(input logic [HALF_W-1:0] x);
    logic [SUBKEY_W-1:0] y;
    int src;
    for (int i = 0; i < SUBKEY_W; i++) begin
      src = ((4 * (i / 6) + (i % 6) - 1 + HALF_W) % HALF_W) + 1;
      y[SUBKEY_W-1-i] = x[HALF_W-src];
    end
    return y;
  endfunction

  function automatic logic [HALF_W-1:0] p_perm(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-P_TAB[i]];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] pc1(input logic [KEY_W-1:0] x);
    logic [CD_W-1:0] y;
    for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = x[KEY_W-PC1_TAB[i]];
    return y;
  endfunction

  function automatic logic [SUBKEY_W-1:0] pc2(input logic [CD_W-1:0] x);
    logic [SUBKEY_W-1:0] y;
    for (int i = 0; i < SUBKEY_W; i++) y[SUBKEY_W-1-i] = x[CD_W-PC2_TAB[i]];
    return y;
  endfunction

endpackage

// File: rtl/des_sbox.sv
module des_sbox
  import des_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [SBOX_IN-1:0]  in_i,
  output logic [SBOX_OUT-1:0] out_o
);

  localparam logic [255:0] TBL = SBOX_TAB[IDX];

  logic [SBOX_IN-1:0] sel;

  // row from outer bits, column from inner bits
  assign sel   = {in_i[5], in_i[0], in_i[4:1]};
  assign out_o = SBOX_OUT'(TBL >> (4 * (63 - int'(sel))));

endmodule

// File: rtl/des_f.sv
module des_f
  import des_pkg::*;
(
  input  logic [HALF_W-1:0]   r_i,
  input  logic [SUBKEY_W-1:0] subkey_i,
  output logic [HALF_W-1:0]   f_o
);

  logic [SUBKEY_W-1:0] mixed;
  logic [HALF_W-1:0]   subst;

  assign mixed = expand(r_i) ^ subkey_i;

  for (genvar g = 0; g < SBOX_N; g++) begin : g_box
    des_sbox #(.IDX(g)) u_box (
      .in_i (mixed[SUBKEY_W-1-SBOX_IN*g -: SBOX_IN]),
      .out_o(subst[HALF_W-1-SBOX_OUT*g -: SBOX_OUT])
    );
  end

  assign f_o = p_perm(subst);

endmodule

// File: rtl/des_key_step.sv
module des_key_step
  import des_pkg::*;
(
  input  logic [CD_W-1:0]     cd_i,
  input  logic [RND_W-1:0]    round_i,
  input  logic                decrypt_i,
  output logic [CD_W-1:0]     cd_o,
  output logic [SUBKEY_W-1:0] subkey_o
);

  logic single, hold;

  // single-step rounds: 1,2,9,16 forward; 2,9,16 reverse; reverse round 1 holds
  always_comb begin
    single = (round_i == RND_W'(1)) || (round_i == RND_W'(8)) ||
             (round_i == RND_W'(ROUNDS - 1)) ||
             (!decrypt_i && round_i == RND_W'(0));
    hold   = decrypt_i && (round_i == RND_W'(0));
  end

  function automatic logic [HCD_W-1:0] rot(input logic [HCD_W-1:0] h,
                                           input logic rev, input logic one,
                                           input logic none);
    if (none)     return h;
    else if (rev) return one ? {h[0], h[HCD_W-1:1]} : {h[1:0], h[HCD_W-1:2]};
    else          return one ? {h[HCD_W-2:0], h[HCD_W-1]} : {h[HCD_W-3:0], h[HCD_W-1:HCD_W-2]};
  endfunction

  assign cd_o     = {rot(cd_i[CD_W-1:HCD_W], decrypt_i, single, hold),
                     rot(cd_i[HCD_W-1:0],    decrypt_i, single, hold)};
  assign subkey_o = pc2(cd_o);

endmodule

// File: rtl/des_iter_core.sv
module des_iter_core
  import des_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               encrypt_i,
  input  logic [BLOCK_W-1:0] data_i,
  input  logic [KEY_W-1:0]   key_i,
  output logic [BLOCK_W-1:0] result_o,
  output logic               done_o
);

  localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

  logic               start_q, busy_q, dec_q, done_q;
  logic [RND_W-1:0]   rnd_q;
  logic [HALF_W-1:0]  l_q, r_q;
  logic [CD_W-1:0]    cd_q;
  logic [BLOCK_W-1:0] result_q;

  logic               accept, last;
  logic [BLOCK_W-1:0] ip_data;
  logic [HALF_W-1:0]  l_src, r_src, f_val, r_new;
  logic [CD_W-1:0]    cd_src, cd_nxt;
  logic [RND_W-1:0]   rnd_src;
  logic               dec_src;
  logic [SUBKEY_W-1:0] subkey;

  assign accept  = start_i && !start_q && !busy_q;
  assign ip_data = init_perm(data_i);

  // round 1 runs straight from the ports on the accepting edge
  always_comb begin
    l_src   = accept ? ip_data[BLOCK_W-1:HALF_W] : l_q;
    r_src   = accept ? ip_data[HALF_W-1:0]       : r_q;
    cd_src  = accept ? pc1(key_i)                : cd_q;
    dec_src = accept ? !encrypt_i                : dec_q;
    rnd_src = accept ? '0                        : rnd_q;
  end

  des_key_step u_key (
    .cd_i     (cd_src),
    .round_i  (rnd_src),
    .decrypt_i(dec_src),
    .cd_o     (cd_nxt),
    .subkey_o (subkey)
  );

  des_f u_f (
    .r_i     (r_src),
    .subkey_i(subkey),
    .f_o     (f_val)
  );

  assign r_new = l_src ^ f_val;
  assign last  = (rnd_src == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      busy_q   <= 1'b0;
      dec_q    <= 1'b0;
      done_q   <= 1'b0;
      rnd_q    <= '0;
      l_q      <= '0;
      r_q      <= '0;
      cd_q     <= '0;
      result_q <= '0;
    end else begin
      start_q <= start_i;
      done_q  <= 1'b0;
      if (accept || busy_q) begin
        l_q   <= r_src;
        r_q   <= r_new;
        cd_q  <= cd_nxt;
        dec_q <= dec_src;
        rnd_q <= rnd_src + RND_W'(1);
        if (last) begin
          // no swap after the final round
          result_q <= final_perm({r_new, r_src});
          done_q   <= 1'b1;
          busy_q   <= 1'b0;
        end else begin
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  a_r4_accept_loads_round: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_q && rnd_q == RND_W'(1));

  a_r5_busy_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rnd_q != LAST) |=> busy_q && rnd_q == $past(rnd_q) + RND_W'(1));

  a_r6_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_q) && $past(rnd_q) == LAST);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

endmodule

// File: tb/sim_des_iter_core.sv
module sim_des_iter_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        enc = 1'b1;
  logic [63:0] data = '0;
  logic [63:0] key = '0;
  logic [63:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  des_iter_core u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .encrypt_i(enc),
    .data_i   (data),
    .key_i    (key),
    .result_o (result),
    .done_o   (done)
  );

  // {key, plaintext, ciphertext}
  localparam int NV = 7;
  localparam logic [191:0] VECS [NV] = '{
    {64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405},
    {64'h0E329232EA6D0D73, 64'h8787878787878787, 64'h0000000000000000},
    {64'h0000000000000000, 64'h0000000000000000, 64'h8CA64DE9C1B123A7},
    {64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h7359B2163E4EDC58},
    {64'h0123456789ABCDEF, 64'h4E6F772069732074, 64'h3FA40E8A984D4815},
    {64'h1111111111111111, 64'h1111111111111111, 64'hF40379AB9E0EC533},
    {64'h0123456789ABCDEF, 64'h1111111111111111, 64'h17668DFC7292532D}};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // call at a negedge; returns at the negedge after the accepting edge
  task automatic launch_now(input logic [63:0] k, input logic [63:0] d, input logic e);
    key = k; data = d; enc = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run(input logic [63:0] k, input logic [63:0] d, input logic e,
                     output logic [63:0] res, output int lat);
    @(negedge clk);
    launch_now(k, d, e);
    wait_done(lat);
    res = result;
    @(negedge clk);
    chk("R7 done pulse width", 64'(done), 64'd0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] res, res2, ct_a;
    int lat;

    repeat (3) @(negedge clk);
    chk("R10 result in reset", result, 64'd0);
    chk("R10 done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 result after reset", result, 64'd0);

    for (int i = 0; i < NV; i++) begin
      run(VECS[i][191:128], VECS[i][127:64], 1'b1, res, lat);
      chk("R1 known-answer encrypt", res, VECS[i][63:0]);
      chk("R6 latency", 64'(lat), 64'd16);
      run(VECS[i][191:128], VECS[i][63:0], 1'b0, res, lat);
      chk("R2 decrypt returns plaintext", res, VECS[i][127:64]);
    end

    // complement property
    run(~VECS[0][191:128], ~VECS[0][127:64], 1'b1, res, lat);
    chk("R1 complement", res, ~VECS[0][63:0]);

    // parity bits flipped
    run(VECS[0][191:128] ^ 64'h0101010101010101, VECS[0][127:64], 1'b1, res, lat);
    chk("R3 parity ignored", res, VECS[0][63:0]);
    run(64'h0101010101010101, 64'h0, 1'b1, res, lat);
    chk("R3 parity-only key", res, 64'h8CA64DE9C1B123A7);

    // weak key: encryption is its own inverse
    run(64'h0101010101010101, 64'h0123456789ABCDEF, 1'b1, res, lat);
    run(64'h0101010101010101, res, 1'b1, res2, lat);
    chk("R1 weak key involution", res2, 64'h0123456789ABCDEF);

    // second start and input changes during a run
    @(negedge clk);
    launch_now(VECS[4][191:128], VECS[4][127:64], 1'b1);
    repeat (4) @(negedge clk);
    key = 64'hFFFF0000FFFF0000; data = 64'h1234; enc = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 6;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R5 ignored start keeps latency", 64'(lat), 64'd16);
    chk("R11 inputs changed mid-run", result, VECS[4][63:0]);
    @(negedge clk);
    chk("R5 no second completion", 64'(done), 64'd0);

    // held start: one operation only
    repeat (2) @(negedge clk);
    key = VECS[5][191:128]; data = VECS[5][127:64]; enc = 1'b1; start = 1'b1;
    @(negedge clk);
    wait_done(lat);
    chk("R4 held start result", result, VECS[5][63:0]);
    lat = 0;
    repeat (24) begin
      @(negedge clk);
      if (done) lat++;
    end
    chk("R4 held start no restart", 64'(lat), 64'd0);
    start = 1'b0;

    // back to back: start raised while done is high
    repeat (2) @(negedge clk);
    launch_now(VECS[0][191:128], VECS[0][127:64], 1'b1);
    wait_done(lat);
    ct_a = result;
    chk("R9 first block", ct_a, VECS[0][63:0]);
    launch_now(VECS[4][191:128], VECS[4][63:0], 1'b0);
    repeat (7) @(negedge clk);
    chk("R8 result held mid-run", result, ct_a);
    lat = 8;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R9 back-to-back period", 64'(lat), 64'd16);
    chk("R9 second block", result, VECS[4][127:64]);

    // reset mid-run aborts
    repeat (2) @(negedge clk);
    launch_now(VECS[6][191:128], VECS[6][127:64], 1'b1);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears result", result, 64'd0);
    rst_n = 1'b1;
    lat = 0;
    repeat (24) begin
      @(negedge clk);
      if (done) lat++;
    end
    chk("R10 aborted run no done", 64'(lat), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule